// File: doc/BRIEF.md
# Set/Clear/Toggle Aliased Register Bank

This block holds a small bank of 32-bit control registers behind a synchronous memory-mapped bus. Each register occupies a 16-byte slot. Address bits [3:2] within that slot pick one of four ways of writing it. A write can replace the whole value, or it can OR, clear or invert only the bits that carry a 1 in the write data. Software can therefore change single flag bits with one write and never needs a read-modify-write sequence.

All register values drive a flat output bus that feeds neighbouring logic. A read at any of the four aliases returns the register's present contents one cycle later. Each register has its own reset value, set by a parameter.

Top module: `alias_reg_bank`

## Requirements
- R1: While rst_ni is low, and after it is released, each register i shows its parameter reset value (by default reg0=0xDEADBEEF, reg1=0x80000001, reg2=0x12345678, reg3=0xFFFFFFFF, reg4=0x00000000, reg5=0xA5A50F0F) and rdata_o is 0.
- R2: A write with addr_i[3:2]=0 replaces the selected register with wdata_i at the next clock edge.
- R3: A write with addr_i[3:2]=1 makes the new value the old value OR wdata_i.
- R4: A write with addr_i[3:2]=2 forces to 0 every bit that is 1 in wdata_i and leaves all other bits as they were.
- R5: A write with addr_i[3:2]=3 makes the new value the old value XOR wdata_i.
- R6: A write changes only the register whose index is addr_i[ADDR_W-1:4]. Every other register keeps its value, and no register changes when we_i is low.
- R7: When re_i is high, rdata_o shows the selected register's value in the following cycle, whatever the alias. When re_i is low, rdata_o holds.
- R8: A write of zero data to the set, clear or toggle alias leaves the register unchanged.
- R9: Address bits [1:0] are ignored, and every write is a full 32-bit write.
- R10: A write to a register index at or above NUM_REGS changes no register. A read at such an index returns 0.
- R11: A read and a write in the same cycle to the same register return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (7) | Byte address: [ADDR_W-1:4] register index, [3:2] alias, [1:0] ignored |
| we_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W (32) | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W (32) | Registered read data |
| regs_o | output | NUM_REGS*DATA_W (192) | All register values, register i at [i*DATA_W +: DATA_W] |

## Verification
Each alias is driven with sparse masks, full-ones masks, alternating-bit patterns and all-zero data. These show whether set, clear and toggle touch only the written bits, and whether a zero mask is a true no-op. The same register is hit with all four operations in turn, so a swap of alias codes, or clear being built as XOR, gives a wrong value. Writes at the first and last register, at misaligned byte addresses and at unused indices show whether the decode selects exactly one register or none. A read issued together with a write shows whether read data is taken before the update.

// File: rtl/alias_reg_pkg.sv
package alias_reg_pkg;
  typedef enum logic [1:0] {
    ALIAS_PLAIN  = 2'd0,
    ALIAS_SET    = 2'd1,
    ALIAS_CLEAR  = 2'd2,
    ALIAS_TOGGLE = 2'd3
  } alias_e;
endpackage

// File: rtl/alias_decode.sv
module alias_decode #(
  parameter int NUM_REGS = 6,
  parameter int IDX_W    = 3,
  parameter int ADDR_W   = IDX_W + 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    we_i,
  output alias_reg_pkg::alias_e   alias_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic                    hit_o,
  output logic [NUM_REGS-1:0]     wsel_o
);
  import alias_reg_pkg::*;

  assign alias_o = alias_e'(addr_i[3:2]);
  assign idx_o   = addr_i[ADDR_W-1:4];
  assign hit_o   = int'(idx_o) < NUM_REGS;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign wsel_o[g] = we_i && (idx_o == IDX_W'(g));
  end

  assert_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wsel_o));
  assert_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (wsel_o == '0));
  // byte lane bits never block a write to a valid slot
  assert_lane_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_o && addr_i[1:0] != 2'b00) |-> (wsel_o != '0));
endmodule

// File: rtl/alias_reg_cell.sv
module alias_reg_cell #(
  parameter int                 DATA_W    = 32,
  parameter logic [DATA_W-1:0]  RESET_VAL = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  alias_reg_pkg::alias_e alias_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     q_o
);
  import alias_reg_pkg::*;

  logic [DATA_W-1:0] q_d;

  always_comb begin
    unique case (alias_i)
      ALIAS_PLAIN:  q_d = wdata_i;
      ALIAS_SET:    q_d = q_o | wdata_i;
      ALIAS_CLEAR:  q_d = q_o & ~wdata_i;
      ALIAS_TOGGLE: q_d = q_o ^ wdata_i;
      default:      q_d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RESET_VAL;
    else if (wr_i) q_o <= q_d;
  end

  assert_plain_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && alias_i == ALIAS_PLAIN) |=> q_o == $past(wdata_i));
  assert_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && alias_i == ALIAS_SET) |=> ((q_o & $past(wdata_i)) == $past(wdata_i))
      && ((q_o & ~$past(wdata_i)) == ($past(q_o) & ~$past(wdata_i))));
  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && alias_i == ALIAS_CLEAR) |=> ((q_o & $past(wdata_i)) == '0)
      && ((q_o & ~$past(wdata_i)) == ($past(q_o) & ~$past(wdata_i))));
  assert_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && alias_i == ALIAS_TOGGLE) |=> ((q_o ^ $past(q_o)) == $past(wdata_i)));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
  assert_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && alias_i != ALIAS_PLAIN && wdata_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/alias_read_mux.sv
module alias_read_mux #(
  parameter int NUM_REGS = 6,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         re_i,
  input  logic                         hit_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [NUM_REGS*DATA_W-1:0]   regs_i,
  output logic [DATA_W-1:0]            rdata_o
);
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (hit_i && idx_i == IDX_W'(k)) rd_d = regs_i[k*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_d;
  end

  assert_rd_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
  assert_rd_miss_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !hit_i) |=> rdata_o == '0);
endmodule

// File: rtl/alias_reg_bank.sv
module alias_reg_bank #(
  parameter int NUM_REGS = 6,
  parameter int DATA_W   = 32,
  parameter logic [NUM_REGS*DATA_W-1:0] RESET_VALS = {
    32'hA5A5_0F0F, 32'h0000_0000, 32'hFFFF_FFFF,
    32'h1234_5678, 32'h8000_0001, 32'hDEAD_BEEF},
  localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int ADDR_W = IDX_W + 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       we_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       re_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  import alias_reg_pkg::*;

  alias_e              alias_sel;
  logic [IDX_W-1:0]    idx;
  logic                hit;
  logic [NUM_REGS-1:0] wsel;

  alias_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .alias_o(alias_sel), .idx_o(idx), .hit_o(hit), .wsel_o(wsel));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    alias_reg_cell #(
      .DATA_W(DATA_W),
      .RESET_VAL(RESET_VALS[g*DATA_W +: DATA_W])
    ) u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wsel[g]), .alias_i(alias_sel),
      .wdata_i(wdata_i), .q_o(regs_o[g*DATA_W +: DATA_W]));
  end

  alias_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .re_i(re_i), .hit_i(hit), .idx_i(idx),
    .regs_i(regs_o), .rdata_o(rdata_o));

  // concurrent read sees the pre-write value
  assert_rd_first_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && we_i && hit) |=> rdata_o == $past(regs_o[idx*DATA_W +: DATA_W]));
endmodule

// File: tb/tb_alias_reg_bank.sv
`timescale 1ns/1ps
module tb_alias_reg_bank;
  localparam int NR = 6;
  localparam int DW = 32;
  localparam int IW = 3;
  localparam int AW = IW + 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          re = 1'b0;
  logic [DW-1:0] rdata;
  logic [NR*DW-1:0] regs;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [DW-1:0] shadow [NR];
  localparam logic [DW-1:0] RST [NR] = '{32'hDEAD_BEEF, 32'h8000_0001,
    32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_0F0F};

  // {idx, alias, data, expected}
  localparam int NV = 16;
  localparam logic [68:0] VEC [NV] = '{
    {3'd2, 2'd0, 32'h0000_00FF, 32'h0000_00FF},
    {3'd2, 2'd1, 32'hF000_0000, 32'hF000_00FF},
    {3'd2, 2'd2, 32'h0000_000F, 32'hF000_00F0},
    {3'd2, 2'd3, 32'hFF00_00FF, 32'h0F00_000F},
    {3'd2, 2'd1, 32'h0000_0000, 32'h0F00_000F},
    {3'd2, 2'd2, 32'h0000_0000, 32'h0F00_000F},
    {3'd2, 2'd3, 32'h0000_0000, 32'h0F00_000F},
    {3'd2, 2'd3, 32'hFFFF_FFFF, 32'hF0FF_FFF0},
    {3'd2, 2'd2, 32'hFFFF_FFFF, 32'h0000_0000},
    {3'd2, 2'd1, 32'h8000_0001, 32'h8000_0001},
    {3'd4, 2'd3, 32'h5555_5555, 32'h5555_5555},
    {3'd4, 2'd1, 32'hAAAA_0000, 32'hFFFF_5555},
    {3'd4, 2'd2, 32'h0F0F_0F0F, 32'hF0F0_5050},
    {3'd4, 2'd0, 32'hCAFE_F00D, 32'hCAFE_F00D},
    {3'd5, 2'd2, 32'hA5A5_0000, 32'h0000_0F0F},
    {3'd0, 2'd1, 32'h2152_4110, 32'hFFFF_FFFF}};

  alias_reg_bank dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .regs_o(regs));

  always #2.5 clk = ~clk;

  function automatic logic [AW-1:0] mk(input logic [IW-1:0] idx,
                                       input logic [1:0] al, input logic [1:0] lane);
    return {idx, al, lane};
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d,
                     input logic r);
    @(negedge clk);
    addr = a; we = w; wdata = d; re = r;
    @(negedge clk);
    we = 1'b0; re = 1'b0;
  endtask

  task automatic chk_all(input string tag);
    for (int j = 0; j < NR; j++) chk(tag, regs[j*DW +: DW], shadow[j]);
  endtask

  initial begin
    for (int j = 0; j < NR; j++) shadow[j] = RST[j];
    #12;
    chk_all("R1 reset held");
    chk("R1 rdata reset", rdata, '0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk_all("R1 after release");

    // vector table: R2..R8
    for (int i = 0; i < NV; i++) begin
      logic [68:0] v;
      v = VEC[i];
      cyc(mk(v[68:66], v[65:64], 2'b00), 1'b1, v[63:32], 1'b0);
      shadow[v[68:66]] = v[31:0];
      chk($sformatf("R2-5 R8 vec%0d alias%0d", i, v[65:64]), regs[v[68:66]*DW +: DW], v[31:0]);
      chk_all("R6 others hold");
      cyc(mk(v[68:66], 2'(i % 4), 2'b00), 1'b0, 32'h0, 1'b1);
      chk("R7 read any alias", rdata, v[31:0]);
    end

    // R9: byte lane bits ignored
    cyc(mk(3'd1, 2'd0, 2'b11), 1'b1, 32'h1111_2222, 1'b0);
    shadow[1] = 32'h1111_2222;
    chk("R9 lane ignored", regs[1*DW +: DW], 32'h1111_2222);
    cyc(mk(3'd1, 2'd1, 2'b01), 1'b1, 32'h0000_0001, 1'b0);
    shadow[1] = 32'h1111_2223;
    chk("R9 lane set", regs[1*DW +: DW], 32'h1111_2223);

    // R10: unused indices
    cyc(mk(3'd6, 2'd0, 2'b00), 1'b1, 32'h7777_7777, 1'b0);
    cyc(mk(3'd7, 2'd1, 2'b00), 1'b1, 32'hFFFF_FFFF, 1'b0);
    chk_all("R10 no write");
    cyc(mk(3'd7, 2'd0, 2'b00), 1'b0, 32'h0, 1'b1);
    chk("R10 read zero", rdata, 32'h0);

    // R11: concurrent read and write
    cyc(mk(3'd3, 2'd2, 2'b00), 1'b1, 32'h0000_FFFF, 1'b1);
    shadow[3] = 32'hFFFF_0000;
    chk("R11 pre-write read", rdata, 32'hFFFF_FFFF);
    chk("R11 write done", regs[3*DW +: DW], 32'hFFFF_0000);

    // R7: rdata holds without re
    cyc(mk(3'd3, 2'd3, 2'b00), 1'b1, 32'h0000_00F0, 1'b0);
    shadow[3] = 32'hFFFF_00F0;
    chk("R7 rdata holds", rdata, 32'hFFFF_FFFF);
    cyc(mk(3'd3, 2'd2, 2'b00), 1'b0, 32'h0, 1'b1);
    chk("R7 read updated", rdata, 32'hFFFF_00F0);

    // R6: we low changes nothing
    cyc(mk(3'd0, 2'd0, 2'b00), 1'b0, 32'h1234_0000, 1'b0);
    chk_all("R6 no we");

    // R1: reset mid-run
    @(negedge clk); rst_ni = 1'b0;
    #1;
    for (int j = 0; j < NR; j++) shadow[j] = RST[j];
    chk_all("R1 re-reset");
    chk("R1 rdata re-reset", rdata, '0);
    @(negedge clk); rst_ni = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule